// File: doc/BRIEF.md
# Logarithmic-domain constant-weighted rotation pair

This block takes two numbers X and Y held in a signed-logarithm format and returns both weighted combinations a1·X + a2·Y and a1·Y − a2·X, where a1 and a2 are fixed coefficients chosen at elaboration, such as the cosine and sine of an eighth of a half turn. Each operand is a zero flag, a sign bit and a two's-complement base-2 logarithm of its magnitude with F fractional bits. Multiplying by a coefficient costs only one fixed-point addition, because the log of the coefficient's magnitude is stored as a parameter and added to the operand's log. A coefficient's sign is folded into the operand sign.

Each output is one log-domain addition of two weighted terms. Out1 combines the a1·X and a2·Y terms. Out2 combines the a1·Y term with the a2·X term after that term's sign has been inverted. Within each pair the term with the larger log is the base. The table address is the non-positive distance z from the smaller term to the base. One set of tables feeds both outputs through two read ports. Each address reads the correction for equal signs, log2(1 + 2^z), and the correction for opposite signs, log2|1 − 2^z|. The effective signs of the two terms pick which correction is added to the base. The result takes the sign of the base, and it is registered once.

Top module: `lns_rot_pair`

## Requirements
- R1: While rst_n is low, both outputs show the zero encoding: zero flag 1, sign 0, log 0.
- R2: With both inputs nonzero, out1 gives the sign of a1·X + a2·Y and its log2 magnitude scaled by 2^F, to within one unit in the last place. The weighted terms are exact values (sign, 2^((log+Lk)/2^F)).
- R3: With both inputs nonzero, out2 gives the sign and log of a1·Y − a2·X to the same tolerance as R2.
- R4: When the two terms of a pair have equal logs and opposite effective signs, that output is the zero encoding: flag 1, sign 0, log 0.
- R5: If X is zero-flagged, out1 equals the a2·Y term and out2 equals the a1·Y term. If Y is zero-flagged, out1 equals the a1·X term and out2 equals the negated a2·X term. If both are zero-flagged, both outputs are zero.
- R6: A result log outside the W-bit signed range saturates to the nearest end, −2^(W−1) or 2^(W−1)−1.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge, and they do not change between edges.
- R8: When the two terms of a pair differ in log by 2^(F+ZB) or more, the result equals the larger term exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_zero | input | 1 | X is zero |
| x_sign | input | 1 | X sign, 1 = negative |
| x_log | input | W | log2 of the magnitude of X, signed, F fractional bits |
| y_zero | input | 1 | Y is zero |
| y_sign | input | 1 | Y sign, 1 = negative |
| y_log | input | W | log2 of the magnitude of Y, signed, F fractional bits |
| r1_zero | output | 1 | Out1 (a1·X + a2·Y) is zero |
| r1_sign | output | 1 | Out1 sign |
| r1_log | output | W | Out1 log magnitude |
| r2_zero | output | 1 | Out2 (a1·Y − a2·X) is zero |
| r2_sign | output | 1 | Out2 sign |
| r2_log | output | W | Out2 log magnitude |

## Verification
All four sign combinations are swept across a grid of log magnitudes. The grid separates the equal-sign correction from the opposite-sign correction, and it shows whether the base is taken from the correct term when either operand leads. Directed cases cover cases the sweep would rarely reach: exact cancellation on each output separately, each operand alone zero-flagged, and both zero-flagged. They also cover a log gap past the end of the table, which must give the larger term bit-exact, and terms below the log range, which must saturate. A seeded random run over a wide range then compares every clock against a real-valued evaluation of both combinations.

// File: rtl/lns_rot_pair.sv
module lns_rot_pair #(
  parameter int W  = 10,
  parameter int F  = 4,
  parameter int ZB = 3,
  parameter int L1 = -2,
  parameter int L2 = -22,
  parameter bit A1NEG = 1'b0,
  parameter bit A2NEG = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                x_zero,
  input  logic                x_sign,
  input  logic signed [W-1:0] x_log,
  input  logic                y_zero,
  input  logic                y_sign,
  input  logic signed [W-1:0] y_log,
  output logic                r1_zero,
  output logic                r1_sign,
  output logic signed [W-1:0] r1_log,
  output logic                r2_zero,
  output logic                r2_sign,
  output logic signed [W-1:0] r2_log
);

  localparam int AW = F + ZB;
  localparam int D  = 1 << AW;
  localparam int SC = 1 << F;
  localparam int WI = W + 2;
  localparam int TW = $clog2((F + 2) << F) + 2;
  localparam logic signed [W-1:0]  LMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  LMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [WI:0]   HI   = {{(WI+1-W){1'b0}}, LMAX};
  localparam logic signed [WI:0]   LO   = {{(WI+1-W){1'b1}}, LMIN};
  localparam logic signed [WI-1:0] C1   = WI'(L1);
  localparam logic signed [WI-1:0] C2   = WI'(L2);

  function automatic logic signed [W-1:0] sat(input logic signed [WI:0] v);
    if (v > HI)      return LMAX;
    else if (v < LO) return LMIN;
    else             return v[W-1:0];
  endfunction

  logic signed [TW-1:0] tab_sb [D];
  logic signed [TW-1:0] tab_db [D];

  for (genvar i = 0; i < D; i++) begin : g_tab
    localparam real ZR  = -1.0 * i / SC;
    localparam real SBR = $ln(1.0 + 2.0 ** ZR) / $ln(2.0);
    localparam real DBR = (i == 0) ? 0.0 : $ln(1.0 - 2.0 ** ZR) / $ln(2.0);
    localparam int  SBQ = $rtoi($floor(SBR * SC + 0.5));
    localparam int  DBQ = $rtoi($floor(DBR * SC + 0.5));
    assign tab_sb[i] = TW'(SBQ);
    assign tab_db[i] = TW'(DBQ);
  end

  wire signed [WI-1:0] xe = {{2{x_log[W-1]}}, x_log};
  wire signed [WI-1:0] ye = {{2{y_log[W-1]}}, y_log};

  logic signed [WI-1:0] p_l [2];
  logic signed [WI-1:0] q_l [2];
  logic p_s [2];
  logic q_s [2];
  logic p_z [2];
  logic q_z [2];

  assign p_l[0] = xe + C1;
  assign p_s[0] = x_sign ^ A1NEG;
  assign p_z[0] = x_zero;
  assign q_l[0] = ye + C2;
  assign q_s[0] = y_sign ^ A2NEG;
  assign q_z[0] = y_zero;

  assign p_l[1] = ye + C1;
  assign p_s[1] = y_sign ^ A1NEG;
  assign p_z[1] = y_zero;
  assign q_l[1] = xe + C2;
  assign q_s[1] = ~(x_sign ^ A2NEG);
  assign q_z[1] = x_zero;

  logic o_z [2];
  logic o_s [2];
  logic signed [W-1:0] o_l [2];

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic                 pb, bs, alike, cancel;
    logic signed [WI-1:0] bl, sl;
    logic [WI-1:0]        dif;
    logic [AW-1:0]        idx;
    logic signed [TW-1:0] tv;
    logic signed [WI:0]   sum;

    assign pb     = p_l[k] >= q_l[k];
    assign bl     = pb ? p_l[k] : q_l[k];
    assign sl     = pb ? q_l[k] : p_l[k];
    assign bs     = pb ? p_s[k] : q_s[k];
    assign dif    = bl - sl;
    assign idx    = (|dif[WI-1:AW]) ? {AW{1'b1}} : dif[AW-1:0];
    assign alike  = p_s[k] == q_s[k];
    assign tv     = alike ? tab_sb[idx] : tab_db[idx];
    assign sum    = {bl[WI-1], bl} + {{(WI+1-TW){tv[TW-1]}}, tv};
    assign cancel = !alike && (dif == '0);

    always_comb begin
      o_z[k] = 1'b0;
      o_s[k] = 1'b0;
      o_l[k] = '0;
      if ((p_z[k] && q_z[k]) || (!p_z[k] && !q_z[k] && cancel)) begin
        o_z[k] = 1'b1;
      end else if (p_z[k]) begin
        o_s[k] = q_s[k];
        o_l[k] = sat({q_l[k][WI-1], q_l[k]});
      end else if (q_z[k]) begin
        o_s[k] = p_s[k];
        o_l[k] = sat({p_l[k][WI-1], p_l[k]});
      end else begin
        o_s[k] = bs;
        o_l[k] = sat(sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_zero <= 1'b1;
      r1_sign <= 1'b0;
      r1_log  <= '0;
      r2_zero <= 1'b1;
      r2_sign <= 1'b0;
      r2_log  <= '0;
    end else begin
      r1_zero <= o_z[0];
      r1_sign <= o_s[0];
      r1_log  <= o_l[0];
      r2_zero <= o_z[1];
      r2_sign <= o_s[1];
      r2_log  <= o_l[1];
    end
  end

endmodule

// File: rtl/lns_rot_pair_chk.sv
module lns_rot_pair_chk #(
  parameter int W  = 10,
  parameter int L1 = -2,
  parameter int L2 = -22,
  parameter bit A1NEG = 1'b0,
  parameter bit A2NEG = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                x_zero,
  input logic                x_sign,
  input logic signed [W-1:0] x_log,
  input logic                y_zero,
  input logic                y_sign,
  input logic signed [W-1:0] y_log,
  input logic                r1_zero,
  input logic                r1_sign,
  input logic signed [W-1:0] r1_log,
  input logic                r2_zero,
  input logic                r2_sign,
  input logic signed [W-1:0] r2_log
);

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  wire signed [W+1:0] tx1 = {{2{x_log[W-1]}}, x_log} + (W+2)'(L1);
  wire signed [W+1:0] ty2 = {{2{y_log[W-1]}}, y_log} + (W+2)'(L2);
  wire both_in  = !x_zero && !y_zero;
  wire opp1     = (x_sign ^ A1NEG) != (y_sign ^ A2NEG);

  AST_ZERO_CANON: assert property (@(posedge clk) disable iff (!rst_n)
    (r1_zero |-> (!r1_sign && r1_log == '0)) and (r2_zero |-> (!r2_sign && r2_log == '0))); // R4

  AST_BOTH_ZERO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(x_zero && y_zero) |-> (r1_zero && r2_zero)); // R5

  AST_X_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(x_zero && !y_zero) |-> (!r1_zero && r1_sign == ($past(y_sign) ^ A2NEG))); // R5

  AST_Y_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(y_zero && !x_zero) |-> (!r2_zero && r2_sign == ~($past(x_sign) ^ A2NEG))); // R5

  AST_CANCEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(both_in && opp1 && tx1 == ty2) |-> r1_zero); // R4

  AST_ALIKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    seen && $past(both_in && !opp1) |-> !r1_zero); // R2

endmodule

bind lns_rot_pair lns_rot_pair_chk #(
  .W(W), .L1(L1), .L2(L2), .A1NEG(A1NEG), .A2NEG(A2NEG)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .x_zero(x_zero), .x_sign(x_sign), .x_log(x_log),
  .y_zero(y_zero), .y_sign(y_sign), .y_log(y_log),
  .r1_zero(r1_zero), .r1_sign(r1_sign), .r1_log(r1_log),
  .r2_zero(r2_zero), .r2_sign(r2_sign), .r2_log(r2_log)
);

// File: tb/lns_rot_pair_tb.sv
`timescale 1ns/1ps
module lns_rot_pair_tb;
  localparam int W  = 10;
  localparam int L1 = -2;
  localparam int L2 = -22;
  localparam bit A1NEG = 1'b0;
  localparam bit A2NEG = 1'b0;
  localparam int LHI = (1 << (W-1)) - 1;
  localparam int LLO = -(1 << (W-1));

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic x_zero, x_sign, y_zero, y_sign;
  logic signed [W-1:0] x_log, y_log;
  logic r1_zero, r1_sign, r2_zero, r2_sign;
  logic signed [W-1:0] r1_log, r2_log;

  lns_rot_pair #(.W(W), .L1(L1), .L2(L2), .A1NEG(A1NEG), .A2NEG(A2NEG)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .x_zero(x_zero), .x_sign(x_sign), .x_log(x_log),
    .y_zero(y_zero), .y_sign(y_sign), .y_log(y_log),
    .r1_zero(r1_zero), .r1_sign(r1_sign), .r1_log(r1_log),
    .r2_zero(r2_zero), .r2_sign(r2_sign), .r2_log(r2_log)
  );

  typedef struct {
    bit xz; bit xs; int xl;
    bit yz; bit ys; int yl;
    string t1; string t2;
    bit has_ex1; int ex1;
  } stim_t;

  stim_t pend[$];
  int n_chk = 0;
  int n_fail = 0;

  function automatic real tval(bit z, bit s, int l);
    if (z) return 0.0;
    return (s ? -1.0 : 1.0) * (2.0 ** (l / 16.0));
  endfunction

  task automatic expect_one(string tag, real v, bit az, bit as, int al, bit has_ex, int ex);
    real el, d;
    n_chk++;
    if (v == 0.0) begin
      if (!az || as || al != 0) begin
        n_fail++;
        $display("FAIL %s: got z=%0b s=%0b log=%0d, expected zero encoding", tag, az, as, al);
      end
    end else begin
      el = $ln(v < 0.0 ? -v : v) / $ln(2.0) * 16.0;
      if (el > LHI) el = LHI;
      if (el < LLO) el = LLO;
      d = al - el;
      if (az || as != (v < 0.0) || d > 1.0 || d < -1.0 || (has_ex && al != ex)) begin
        n_fail++;
        $display("FAIL %s: got z=%0b s=%0b log=%0d, expected z=0 s=%0b log=%f", tag, az, as, al,
                 v < 0.0, has_ex ? real'(ex) : el);
      end
    end
  endtask

  task automatic check_prev();
    stim_t s;
    real a1x, a2x, a1y, a2y;
    s = pend.pop_front();
    a1x = tval(s.xz, s.xs ^ A1NEG, s.xl + L1);
    a2x = tval(s.xz, s.xs ^ A2NEG, s.xl + L2);
    a1y = tval(s.yz, s.ys ^ A1NEG, s.yl + L1);
    a2y = tval(s.yz, s.ys ^ A2NEG, s.yl + L2);
    expect_one(s.t1, a1x + a2y, r1_zero, r1_sign, int'(r1_log), s.has_ex1, s.ex1);
    expect_one(s.t2, a1y - a2x, r2_zero, r2_sign, int'(r2_log), 1'b0, 0);
  endtask

  task automatic apply(stim_t s);
    x_zero = s.xz; x_sign = s.xs; x_log = W'(s.xl);
    y_zero = s.yz; y_sign = s.ys; y_log = W'(s.yl);
    pend.push_back(s);
  endtask

  task automatic step(bit xz, bit xs, int xl, bit yz, bit ys, int yl,
                      string t1, string t2, bit has_ex1, int ex1);
    stim_t s;
    s.xz = xz; s.xs = xs; s.xl = xl; s.yz = yz; s.ys = ys; s.yl = yl;
    s.t1 = t1; s.t2 = t2; s.has_ex1 = has_ex1; s.ex1 = ex1;
    @(negedge clk);
    if (pend.size() > 0) check_prev();
    apply(s);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got a hung run, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    x_zero = 1'b1; x_sign = 1'b0; x_log = '0;
    y_zero = 1'b1; y_sign = 1'b0; y_log = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (!r1_zero || r1_sign || r1_log != 0 || !r2_zero || r2_sign || r2_log != 0) begin
      n_fail++;
      $display("FAIL R1: got r1=%0b/%0b/%0d r2=%0b/%0b/%0d, expected zero encoding",
               r1_zero, r1_sign, r1_log, r2_zero, r2_sign, r2_log);
    end
    rst_n = 1'b1;

    step(0, 0, 0, 0, 1, 20, "R4", "R3", 0, 0);
    step(0, 0, 10, 0, 0, -10, "R2", "R4", 0, 0);
    step(0, 1, 10, 0, 1, -10, "R2", "R4", 0, 0);
    step(1, 0, 0, 0, 1, 37, "R5", "R5", 1, 37 + L2);
    step(0, 1, -25, 1, 0, 0, "R5", "R5", 1, -25 + L1);
    step(1, 1, 5, 1, 0, 9, "R5", "R5", 0, 0);
    step(0, 0, 0, 0, 0, -200, "R8", "R3", 1, L1);
    step(0, 1, 100, 0, 0, -120, "R8", "R3", 1, 100 + L1);
    step(1, 0, 0, 0, 0, LLO, "R6", "R6", 1, LLO);
    step(0, 0, LLO, 0, 1, LLO, "R6", "R6", 0, 0);
    step(0, 0, 3, 0, 0, 3, "R2", "R3", 0, 0);

    // R7: output holds between edges, then follows the new input
    begin
      stim_t s;
      logic signed [W-1:0] hold;
      logic hz;
      @(negedge clk);
      check_prev();
      hold = r1_log; hz = r1_zero;
      s.xz = 0; s.xs = 0; s.xl = 60; s.yz = 0; s.ys = 0; s.yl = -60;
      s.t1 = "R7"; s.t2 = "R7"; s.has_ex1 = 0; s.ex1 = 0;
      apply(s);
      #1;
      n_chk++;
      if (r1_log != hold || r1_zero != hz) begin
        n_fail++;
        $display("FAIL R7: got log=%0d z=%0b before edge, expected %0d z=%0b", r1_log, r1_zero, hold, hz);
      end
    end

    for (int sx = 0; sx < 2; sx++)
      for (int sy = 0; sy < 2; sy++)
        for (int xl = -40; xl <= 40; xl += 9)
          for (int yl = -40; yl <= 40; yl += 11)
            step(0, sx[0], xl, 0, sy[0], yl, "R2", "R3", 0, 0);

    begin
      int unsigned seed;
      seed = $urandom(7);
      for (int i = 0; i < 600; i++) begin
        int xl, yl;
        xl = int'($urandom_range(600)) - 300;
        yl = xl + int'($urandom_range(80)) - 40;
        step(0, $urandom_range(1), xl, 0, $urandom_range(1), yl, "R2", "R3", 0, 0);
      end
    end

    @(negedge clk);
    check_prev();
    finish_run();
  end
endmodule